// File: doc/BRIEF.md
# Serial ADC Channel Scan Controller

This block is the host end of a link to a 10-bit serial ADC with four address bits per conversion. It scans a fixed range of analog channels without pause, one 16-bit full-duplex frame at a time. Each frame shifts out the address of the channel to convert next and shifts in the result of the conversion that the previous frame requested. Because the converter always returns the result of the preceding request, the block keeps the address it sent last and uses it as the tag for the value it receives next. The first frame after reset only primes the converter, so its data is dropped.

The serial clock comes from a programmable half-period divider. The link runs in clock-idle-low fashion: outgoing data changes on the falling edge and incoming data is sampled on the rising edge. Chip select is held low for exactly one frame. The frame can be sent as one 16-clock burst or as two 8-clock bytes with an idle gap between them. Between frames the block gives the converter time to finish. In counted mode it waits a fixed number of rising edges of a conversion clock that it generates itself. In flag mode it waits for a rising edge on the end-of-conversion input.

Each value leaves on a valid/ready stream that carries a 4-bit channel tag and a 10-bit value. Once valid is raised, tag and value hold steady until ready is seen high at a clock edge. While a result waits for ready, no new frame starts, so back-pressure pauses the scan and no value is lost.

Top module: `adc_scan_host`

## Requirements
- R1: While reset is held and just after it is released, chip select is high, the serial clock is low and no result is valid.
- R2: Every chip-select-low window holds exactly 16 rising serial clock edges. The clock idles low. Each high phase and each low phase lasts max(div_i,1) clock cycles, except the byte gap of R8. Outgoing data changes only at falling edges, and incoming data is sampled at rising edges.
- R3: The first four bits sent in a frame are the channel address, MSB first. The remaining 12 bits are zero.
- R4: The 16 received bits form a word whose first bit is bit 15. The emitted value is bits 15..6 of that word, and the low 6 bits are discarded.
- R5: Frames address channels 0, 1, ..., LAST_CHAN and then wrap to 0. Each emitted value carries the address sent in the previous frame. The frame that follows reset emits nothing, so the first tag out is 0.
- R6: With flag_mode_i low, chip select stays high after a frame for at least WAIT_CONV rising edges of conv_clk_o. The conversion clock has a half period of CONV_HALF cycles.
- R7: With flag_mode_i high, the next frame starts only after eoc_i rises following the end of the previous frame, and it starts within a few cycles of that edge.
- R8: With split_i high, the serial clock stays low for (1+GAP_HALVES) half periods between the 8th and the 9th bit, and chip select stays low during this gap. With split_i low, no such gap occurs.
- R9: res_valid_o stays high with a steady tag and value until res_ready_i is sampled high. No frame starts while a result is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Serial clock half period in clk cycles (0 behaves as 1) |
| flag_mode_i | input | 1 | 1: wait for end-of-conversion edge; 0: counted wait |
| split_i | input | 1 | 1: send each frame as two bytes with a gap |
| eoc_i | input | 1 | End-of-conversion flag from the converter |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the converter |
| cs_n_o | output | 1 | Active-low chip select |
| conv_clk_o | output | 1 | Free-running conversion clock |
| res_valid_o | output | 1 | Result stream valid |
| res_ready_i | input | 1 | Result stream ready |
| res_chan_o | output | 4 | Channel tag of the result |
| res_data_o | output | 10 | 10-bit conversion value |

## Verification
The bench builds the block with LAST_CHAN 8, WAIT_CONV 44, CONV_HALF 2 and GAP_HALVES 4. With these values the counted wait is about 176 cycles, so a scan wraps from channel 8 to 0 within a short run. A flag-mode wait of 60 cycles is then clearly shorter than the counted window, and a 300-cycle wait is clearly longer, which tells the two modes apart. The byte gap of 4 extra half periods is easy to tell from a normal low phase at divider values 0, 2 and 3.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int FRAME_BITS = 16;
  localparam int ADDR_BITS  = 4;
  localparam int RES_BITS   = 10;
  localparam int PAD_BITS   = FRAME_BITS - RES_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {
    SEQ_BOOT   = 2'd0,
    SEQ_LAUNCH = 2'd1,
    SEQ_XFER   = 2'd2,
    SEQ_WAIT   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/adc_scan_shifter.sv
module adc_scan_shifter
  import adc_scan_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int GAP_HALVES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      div_i,
  input  logic                  split_i,
  input  logic                  start_i,
  input  logic [ADDR_BITS-1:0]  addr_i,
  input  logic                  miso_i,
  output logic                  sclk_o,
  output logic                  mosi_o,
  output logic                  cs_n_o,
  output logic                  done_o,
  output logic [FRAME_BITS-1:0] rx_o
);
  localparam int GAP_W = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] MID_BIT  = CNT_W'(FRAME_BITS / 2);

  logic                  active;
  logic [DIV_W-1:0]      hcnt;
  logic [DIV_W-1:0]      eff_div;
  logic                  tick;
  logic [CNT_W-1:0]      bitcnt;
  logic                  in_gap;
  logic [GAP_W-1:0]      gap_cnt;
  logic [FRAME_BITS-1:0] tx;

  assign eff_div = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick    = active && ((hcnt + DIV_W'(1)) >= eff_div);
  assign mosi_o  = tx[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      hcnt    <= '0;
      bitcnt  <= '0;
      in_gap  <= 1'b0;
      gap_cnt <= '0;
      tx      <= '0;
      rx_o    <= '0;
      sclk_o  <= 1'b0;
      cs_n_o  <= 1'b1;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active) begin
        if (start_i) begin
          active <= 1'b1;
          cs_n_o <= 1'b0;
          sclk_o <= 1'b0;
          hcnt   <= '0;
          bitcnt <= '0;
          in_gap <= 1'b0;
          tx     <= {addr_i, {(FRAME_BITS-ADDR_BITS){1'b0}}};
        end
      end else if (!tick) begin
        hcnt <= hcnt + DIV_W'(1);
      end else begin
        hcnt <= '0;
        if (in_gap) begin
          if (gap_cnt == GAP_W'(GAP_HALVES - 1)) in_gap <= 1'b0;
          else gap_cnt <= gap_cnt + GAP_W'(1);
        end else if (!sclk_o) begin
          sclk_o <= 1'b1;
          rx_o   <= {rx_o[FRAME_BITS-2:0], miso_i};
          bitcnt <= bitcnt + CNT_W'(1);
        end else begin
          sclk_o <= 1'b0;
          if (bitcnt == LAST_BIT) begin
            active <= 1'b0;
            cs_n_o <= 1'b1;
            done_o <= 1'b1;
            tx     <= '0;
          end else begin
            tx <= {tx[FRAME_BITS-2:0], 1'b0};
            if (split_i && (GAP_HALVES > 0) && (bitcnt == MID_BIT)) begin
              in_gap  <= 1'b1;
              gap_cnt <= '0;
            end
          end
        end
      end
    end
  end

  // R2: serial clock idles low whenever chip select is released
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  // R2: outgoing data does not move at a rising edge
  assert_mosi_rise_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(mosi_o));

  // R3: after the address nibble has been clocked out, only zeros follow
  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && (bitcnt > CNT_W'(ADDR_BITS))) |-> !mosi_o);

  // R8: during the byte gap the clock is low and the frame stays selected
  assert_gap_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> (!sclk_o && !cs_n_o));
endmodule

// File: rtl/adc_scan_waiter.sv
module adc_scan_waiter #(
  parameter int WAIT_CONV = 44,
  parameter int CONV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic flag_mode_i,
  input  logic eoc_i,
  output logic conv_clk_o,
  output logic done_o
);
  localparam int HW = (CONV_HALF > 1) ? $clog2(CONV_HALF) : 1;
  localparam int WW = $clog2(WAIT_CONV + 1);

  logic [HW-1:0] hcnt;
  logic          toggle;
  logic          conv_rise;
  logic          eoc_q;
  logic          waiting;
  logic [WW-1:0] cnt;

  assign toggle    = (hcnt == HW'(CONV_HALF - 1));
  assign conv_rise = toggle && !conv_clk_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt       <= '0;
      conv_clk_o <= 1'b0;
    end else if (toggle) begin
      hcnt       <= '0;
      conv_clk_o <= !conv_clk_o;
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_q   <= 1'b0;
      waiting <= 1'b0;
      cnt     <= '0;
      done_o  <= 1'b0;
    end else begin
      eoc_q <= eoc_i;
      if (start_i) begin
        waiting <= 1'b1;
        done_o  <= 1'b0;
        cnt     <= '0;
      end else if (waiting) begin
        if (flag_mode_i) begin
          if (eoc_i && !eoc_q) begin
            waiting <= 1'b0;
            done_o  <= 1'b1;
          end
        end else if (conv_rise) begin
          if (cnt == WW'(WAIT_CONV - 1)) begin
            waiting <= 1'b0;
            done_o  <= 1'b1;
          end else begin
            cnt <= cnt + WW'(1);
          end
        end
      end
    end
  end

  // R6: the conversion-edge count never runs past its window
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (cnt < WW'(WAIT_CONV)));

  // R7: in flag mode completion follows a high end-of-conversion input
  assert_flag_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_o) && flag_mode_i && $past(flag_mode_i)) |-> $past(eoc_i));
endmodule

// File: rtl/adc_scan_host.sv
module adc_scan_host
  import adc_scan_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int LAST_CHAN  = 8,
  parameter int WAIT_CONV  = 44,
  parameter int CONV_HALF  = 2,
  parameter int GAP_HALVES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 flag_mode_i,
  input  logic                 split_i,
  input  logic                 eoc_i,
  input  logic                 miso_i,
  output logic                 sclk_o,
  output logic                 mosi_o,
  output logic                 cs_n_o,
  output logic                 conv_clk_o,
  output logic                 res_valid_o,
  input  logic                 res_ready_i,
  output logic [ADDR_BITS-1:0] res_chan_o,
  output logic [RES_BITS-1:0]  res_data_o
);
  localparam logic [ADDR_BITS-1:0] LAST_ADDR = ADDR_BITS'(LAST_CHAN);

  seq_state_t            state;
  logic [ADDR_BITS-1:0]  cur_addr;
  logic [ADDR_BITS-1:0]  prev_addr;
  logic                  have_prev;
  logic                  shift_start;
  logic                  shift_done;
  logic [FRAME_BITS-1:0] rx_word;
  logic                  wait_start;
  logic                  wait_done;
  logic                  slot_free;

  assign shift_start = (state == SEQ_LAUNCH);
  assign wait_start  = (state == SEQ_XFER) && shift_done;
  assign slot_free   = !res_valid_o || res_ready_i;

  adc_scan_shifter #(
    .DIV_W      (DIV_W),
    .GAP_HALVES (GAP_HALVES)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_i   (div_i),
    .split_i (split_i),
    .start_i (shift_start),
    .addr_i  (cur_addr),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .cs_n_o  (cs_n_o),
    .done_o  (shift_done),
    .rx_o    (rx_word)
  );

  adc_scan_waiter #(
    .WAIT_CONV (WAIT_CONV),
    .CONV_HALF (CONV_HALF)
  ) u_wait (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (wait_start),
    .flag_mode_i (flag_mode_i),
    .eoc_i       (eoc_i),
    .conv_clk_o  (conv_clk_o),
    .done_o      (wait_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_BOOT;
      cur_addr  <= '0;
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else begin
      unique case (state)
        SEQ_BOOT:   state <= SEQ_LAUNCH;
        SEQ_LAUNCH: state <= SEQ_XFER;
        SEQ_XFER: begin
          if (shift_done) begin
            prev_addr <= cur_addr;
            have_prev <= 1'b1;
            cur_addr  <= (cur_addr == LAST_ADDR) ? '0 : cur_addr + ADDR_BITS'(1);
            state     <= SEQ_WAIT;
          end
        end
        SEQ_WAIT: begin
          if (wait_done && slot_free) state <= SEQ_LAUNCH;
        end
        default: state <= SEQ_BOOT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      res_chan_o  <= '0;
      res_data_o  <= '0;
    end else begin
      if (res_valid_o && res_ready_i) res_valid_o <= 1'b0;
      if (wait_start && have_prev) begin
        res_valid_o <= 1'b1;
        res_chan_o  <= prev_addr;
        res_data_o  <= rx_word[FRAME_BITS-1:PAD_BITS];
      end
    end
  end

  // R9: a pending result holds still until accepted
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_chan_o) && $stable(res_data_o)));

  // R9: a frame never opens while a result is still pending
  assert_no_launch_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !res_valid_o);

  // R5: tags stay inside the scanned range
  assert_tag_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (res_chan_o <= LAST_ADDR));

  // R1: nothing is emitted before the first frame completes
  assert_no_early_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid_o) |-> $past(cs_n_o));
endmodule

// File: tb/tb_adc_scan_host.sv
`timescale 1ns/1ps
module tb_adc_scan_host;
  localparam int LAST_CHAN  = 8;
  localparam int WAIT_CONV  = 44;
  localparam int CONV_HALF  = 2;
  localparam int GAP_HALVES = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_i = 8'd2;
  logic       flag_mode_i = 1'b0;
  logic       split_i = 1'b0;
  logic       eoc_i = 1'b0;
  logic       miso_i = 1'b0;
  logic       sclk_o, mosi_o, cs_n_o, conv_clk_o, res_valid_o;
  logic       res_ready_i = 1'b1;
  logic [3:0] res_chan_o;
  logic [9:0] res_data_o;

  always #2.5 clk = ~clk;

  adc_scan_host #(
    .DIV_W(8), .LAST_CHAN(LAST_CHAN), .WAIT_CONV(WAIT_CONV),
    .CONV_HALF(CONV_HALF), .GAP_HALVES(GAP_HALVES)
  ) dut (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .flag_mode_i(flag_mode_i),
    .split_i(split_i), .eoc_i(eoc_i), .miso_i(miso_i), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .cs_n_o(cs_n_o), .conv_clk_o(conv_clk_o),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
    .res_chan_o(res_chan_o), .res_data_o(res_data_o)
  );

  int vectors = 0;
  int fails = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int conv_val(input int ch);
    return (ch * 113 + 37) & 10'h3FF;
  endfunction

  // ---------------- converter model ----------------
  logic [15:0] dev_word = 16'hFFC0;
  logic [15:0] dev_rx = '0;
  int          dev_idx = 0;
  int          dev_rises = 0;

  always @(negedge cs_n_o) begin
    dev_idx = 0;
    dev_rises = 0;
    dev_rx = '0;
    miso_i = dev_word[15];
  end

  always @(posedge sclk_o) begin
    if (!cs_n_o) begin
      dev_rx = {dev_rx[14:0], mosi_o};
      dev_rises++;
    end
  end

  always @(negedge sclk_o) begin
    if (dev_idx < 15) begin
      dev_idx++;
      miso_i = dev_word[15 - dev_idx];
    end
  end

  // ---------------- monitors ----------------
  int  eoc_delay = 60;
  int  eoc_cnt = 0;
  bit  cs_prev = 1'b1;
  bit  seen_rise = 0;
  int  gap_cyc = 0;
  int  low_run = 0, high_run = 0, max_low = 0, max_high = 0;
  int  cyc = 0;
  int  exp_mode = 0;      // 0 none, 1 counted, 2 flag
  int  exp_half = 2;
  bit  exp_timing = 0;
  bit  exp_split = 0;
  int  cs_falls = 0;
  int  recv = 0;
  int  exp_tag = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      check(0, "watchdog", cyc, 150000);
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
    if (cs_n_o && !cs_prev) begin
      // frame just ended
      check(dev_rises == 16, "R2 rising edges per frame", dev_rises, 16);
      check(dev_rx[11:0] == 12'h000, "R3 padding bits zero", int'(dev_rx[11:0]), 0);
      if (high_run > max_high) max_high = high_run;
      if (exp_timing) begin
        check(max_high == exp_half, "R2 high phase length", max_high, exp_half);
        check(max_low == (exp_split ? exp_half * (1 + GAP_HALVES) : exp_half),
              "R8 longest low phase", max_low,
              exp_split ? exp_half * (1 + GAP_HALVES) : exp_half);
      end
      dev_word = {conv_val(int'(dev_rx[15:12]))[9:0], 6'b0};
      seen_rise = 1;
      gap_cyc = 0;
      eoc_cnt = 0;
      eoc_i = 1'b0;
    end
    if (!cs_n_o && cs_prev) begin
      cs_falls++;
      if (seen_rise && exp_mode == 1)
        check(gap_cyc >= (WAIT_CONV - 1) * 2 * CONV_HALF &&
              gap_cyc <= WAIT_CONV * 2 * CONV_HALF + 10,
              "R6 counted wait length", gap_cyc, WAIT_CONV * 2 * CONV_HALF);
      if (seen_rise && exp_mode == 2)
        check(gap_cyc >= eoc_delay && gap_cyc <= eoc_delay + 10,
              "R7 flag wait length", gap_cyc, eoc_delay);
      low_run = 0; high_run = 0; max_low = 0; max_high = 0;
    end
    if (cs_n_o) begin
      gap_cyc++;
      eoc_cnt++;
      if (eoc_cnt >= eoc_delay) eoc_i = 1'b1;
      check(!sclk_o, "R2 clock idle low", int'(sclk_o), 0);
    end else begin
      if (sclk_o) begin
        if (low_run > max_low) max_low = low_run;
        low_run = 0;
        high_run++;
      end else begin
        if (high_run > max_high) max_high = high_run;
        high_run = 0;
        low_run++;
      end
    end
    cs_prev = cs_n_o;
    // result stream collector
    if (res_valid_o && res_ready_i) begin
      check(int'(res_chan_o) == exp_tag, "R5 channel tag order", int'(res_chan_o), exp_tag);
      check(int'(res_data_o) == conv_val(exp_tag), "R4 value alignment",
            int'(res_data_o), conv_val(exp_tag));
      exp_tag = (exp_tag == LAST_CHAN) ? 0 : exp_tag + 1;
      recv++;
    end
  end

  task automatic wait_results(input int n);
    int target = recv + n;
    while (recv < target) @(posedge clk);
    #1;
  endtask

  task automatic setup(input int div, input bit flag, input bit split, input int mode);
    @(posedge clk); #1;
    exp_timing = 0; exp_mode = 0;
    div_i = 8'(div); flag_mode_i = flag; split_i = split;
    wait_results(2);
    exp_half = (div == 0) ? 1 : div;
    exp_split = split;
    exp_timing = 1;
    exp_mode = mode;
  endtask

  task automatic t_reset();
    #1;
    repeat (3) @(negedge clk);
    check(cs_n_o == 1'b1, "R1 chip select high in reset", int'(cs_n_o), 1);
    check(sclk_o == 1'b0, "R1 clock low in reset", int'(sclk_o), 0);
    check(res_valid_o == 1'b0, "R1 no valid in reset", int'(res_valid_o), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(res_valid_o == 1'b0, "R1 no valid after release", int'(res_valid_o), 0);
  endtask

  task automatic t_counted_burst();
    // covers R5 first tag 0 and wrap from LAST_CHAN to 0
    wait_results(1);
    setup(2, 0, 0, 1);
    wait_results(12);
  endtask

  task automatic t_counted_split();
    setup(3, 0, 1, 1);   // R8 byte gap with half period 3
    wait_results(3);
  endtask

  task automatic t_div_zero();
    setup(0, 0, 1, 1);   // R2 divider 0 acts as 1
    wait_results(3);
  endtask

  task automatic t_flag_long();
    eoc_delay = 300;
    setup(2, 1, 0, 2);   // R7 flag wait longer than counted window
    wait_results(3);
  endtask

  task automatic t_flag_short();
    eoc_delay = 60;
    setup(2, 1, 1, 2);   // R7 flag wait shorter than counted window
    wait_results(3);
  endtask

  task automatic t_backpressure();
    int falls0;
    logic [3:0] c0;
    logic [9:0] d0;
    exp_mode = 0;
    @(posedge clk); #1 res_ready_i = 1'b0;
    while (!res_valid_o) @(negedge clk);
    c0 = res_chan_o; d0 = res_data_o;
    @(negedge clk);
    falls0 = cs_falls;
    repeat (800) @(negedge clk);
    check(res_valid_o == 1'b1, "R9 valid held", int'(res_valid_o), 1);
    check(res_chan_o == c0, "R9 tag stable", int'(res_chan_o), int'(c0));
    check(res_data_o == d0, "R9 value stable", int'(res_data_o), int'(d0));
    check(cs_falls == falls0, "R9 no frame while pending", cs_falls - falls0, 0);
    @(posedge clk); #1 res_ready_i = 1'b1;
    wait_results(3);
  endtask

  initial begin
    t_reset();
    t_counted_burst();
    t_counted_split();
    t_div_zero();
    t_flag_long();
    t_flag_short();
    t_backpressure();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule